// File: doc/BRIEF.md
# Multi-Channel Edge Capture Unit

The unit samples a free-running timer value whenever an external pin shows a chosen transition. It has four independent channels. Each channel has its own input pin, its own 32-bit snapshot register and its own sticky interrupt flag. Every channel can fire on rising transitions, on falling transitions or on both. Pins pass through a two-stage synchronizer, and the snapshot lands a fixed number of clock cycles after the pin moves.

The same qualified transitions can also drive the tick input of a downstream counter. In counter mode, the count-enable output gives a one-cycle pulse for each qualifying transition on one source channel, and this replaces the prescaled clock tick. The source is the lowest-numbered channel that is set in a source mask. In timer mode, the output passes the prescaled tick through unchanged.

Top module: `edge_capture_unit`

## Requirements
- R1: After a synchronous active-low reset, every snapshot register, every interrupt flag and the combined interrupt are zero.
- R2: Channel i has a 2-bit transition select in `ch_edge_cfg[2i+1:2i]`. Bit 2i enables rising transitions, bit 2i+1 enables falling transitions, and setting both enables both.
- R3: When a pin changes between clock edges, the third rising clock edge after the change loads that channel's snapshot register with `timer_val` as sampled at that edge.
- R4: A channel whose select is 00 never changes its snapshot register and never sets its flag, whatever its pin does.
- R5: A capture on channel i sets `irq_flag[i]` only when `ch_irq_en[i]` is 1. `irq` is high whenever any flag is set.
- R6: Flags hold until `irq_clr[i]` is 1 at a clock edge, which clears the flag. A capture at the same edge wins over the clear.
- R7: With `cnt_mode` = 1, each qualifying transition on the source channel gives exactly one cycle of `count_pulse`. That cycle ends at the edge that loads the snapshot.
- R8: The source channel is the lowest set bit of `cnt_src_sel`. Transitions on the other selected channels produce no pulses, and a mask of zero gives no pulses.
- R9: With `cnt_mode` = 0, `count_pulse` equals `presc_tick` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_pins | input | 4 | Asynchronous capture pins, one per channel |
| timer_val | input | 32 | Current timer value to snapshot |
| ch_edge_cfg | input | 8 | Transition select, two bits per channel |
| ch_irq_en | input | 4 | Per-channel interrupt enable |
| irq_clr | input | 4 | Write-one-to-clear pulses for the flags |
| cnt_mode | input | 1 | 1 selects counter mode, 0 selects timer mode |
| cnt_src_sel | input | 4 | Mask of candidate count-source channels |
| presc_tick | input | 1 | Prescaled clock tick used in timer mode |
| cap_val | output | 128 | Snapshot registers; channel i at bits [32i+31:32i] |
| irq_flag | output | 4 | Sticky per-channel interrupt flags |
| irq | output | 1 | OR of all flags |
| count_pulse | output | 1 | Count enable for the downstream counter |

## Verification
The one-pulse-per-transition property assumes that a pin holds its level for at least two clock cycles between changes. It also assumes that pins are low when reset is released. The stimulus toggles each pin only at falling clock edges, keeps every level for three or more cycles and starts with all pins low. Configuration is changed only while the pins are quiet, so that the bench's edge model always matches the select in force.

// File: rtl/capt_pkg.sv
// Shared types for the edge capture unit.
// Assumes: nothing beyond a standard SystemVerilog compile order.
package capt_pkg;

    // Per-channel transition select. Bit 0 enables rising, bit 1 enables falling.
    typedef struct packed {
        logic fall;
        logic rise;
    } edge_cfg_t;

    localparam int unsigned CFG_W = $bits(edge_cfg_t);

endpackage

// File: rtl/capt_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes: each bit is independent; no bus coherency is implied.
module capt_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/capt_channel.sv
// One capture channel: detects the transitions it is set for, snapshots the
// timer value and keeps a sticky interrupt flag.
// Assumes: pin_s is already synchronized and is low when reset is released.
module capt_channel
    import capt_pkg::*;
#(
    parameter int unsigned TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_s,
    input  edge_cfg_t     cfg,
    input  logic          irq_en,
    input  logic          irq_clr,
    input  logic [TW-1:0] timer_val,
    output logic [TW-1:0] cap_q,
    output logic          flag_q,
    output logic          event_o
);

    logic pin_prev;
    logic rise_seen;
    logic fall_seen;

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_s;
    end

    // Qualify the detected transition with the channel's select.
    always_comb begin
        rise_seen = pin_s & ~pin_prev;
        fall_seen = ~pin_s & pin_prev;
        event_o   = (rise_seen & cfg.rise) | (fall_seen & cfg.fall);
    end

    // Snapshot the timer value on a qualified transition.
    always_ff @(posedge clk) begin
        if (!rst_n)       cap_q <= '0;
        else if (event_o) cap_q <= timer_val;
    end

    // Sticky flag: a capture sets it (and wins), a clear request drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (event_o & irq_en) flag_q <= 1'b1;
        else if (irq_clr)          flag_q <= 1'b0;
    end

endmodule

// File: rtl/capt_cnt_src.sv
// Count-enable source: either the prescaled tick or the qualified events of
// the lowest-numbered channel in the source mask.
// Assumes: event inputs are single-cycle pulses from the channels.
module capt_cnt_src #(
    parameter int unsigned NUM_CH = 4
) (
    input  logic [NUM_CH-1:0] ch_event,
    input  logic [NUM_CH-1:0] src_sel,
    input  logic              cnt_mode,
    input  logic              presc_tick,
    output logic              count_pulse
);

    logic src_hit;
    logic src_evt;

    // Priority pick: the first set mask bit from index 0 upward.
    always_comb begin
        src_hit = 1'b0;
        src_evt = 1'b0;
        for (int i = 0; i < int'(NUM_CH); i++) begin
            if (!src_hit && src_sel[i]) begin
                src_hit = 1'b1;
                src_evt = ch_event[i];
            end
        end
    end

    // Choose between counter-mode events and the prescaled tick.
    always_comb begin
        count_pulse = cnt_mode ? src_evt : presc_tick;
    end

endmodule

// File: rtl/edge_capture_unit.sv
// Top level of the four-channel edge capture unit: synchronizes the pins,
// runs one capture channel per pin and produces the count enable.
// Assumes: timer_val is generated elsewhere in the same clock domain.
module edge_capture_unit
    import capt_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned TW          = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CH-1:0]    cap_pins,
    input  logic [TW-1:0]        timer_val,
    input  logic [NUM_CH*2-1:0]  ch_edge_cfg,
    input  logic [NUM_CH-1:0]    ch_irq_en,
    input  logic [NUM_CH-1:0]    irq_clr,
    input  logic                 cnt_mode,
    input  logic [NUM_CH-1:0]    cnt_src_sel,
    input  logic                 presc_tick,
    output logic [NUM_CH*TW-1:0] cap_val,
    output logic [NUM_CH-1:0]    irq_flag,
    output logic                 irq,
    output logic                 count_pulse
);

    localparam int unsigned CW = CFG_W;

    logic [NUM_CH-1:0] pins_s;
    logic [NUM_CH-1:0] ch_event;

    capt_sync #(
        .WIDTH  (NUM_CH),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cap_pins),
        .q_sync  (pins_s)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            capt_channel #(
                .TW (TW)
            ) chan_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_s     (pins_s[c]),
                .cfg       (edge_cfg_t'(ch_edge_cfg[c*CW +: CW])),
                .irq_en    (ch_irq_en[c]),
                .irq_clr   (irq_clr[c]),
                .timer_val (timer_val),
                .cap_q     (cap_val[c*TW +: TW]),
                .flag_q    (irq_flag[c]),
                .event_o   (ch_event[c])
            );
        end
    endgenerate

    capt_cnt_src #(
        .NUM_CH (NUM_CH)
    ) src_i (
        .ch_event    (ch_event),
        .src_sel     (cnt_src_sel),
        .cnt_mode    (cnt_mode),
        .presc_tick  (presc_tick),
        .count_pulse (count_pulse)
    );

    // Combined interrupt request.
    always_comb begin
        irq = |irq_flag;
    end

endmodule

// File: rtl/edge_capture_unit_chk.sv
// Property checker for edge_capture_unit, attached with bind below.
// Assumes: pins hold each level for at least two cycles.
module edge_capture_unit_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned TW     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CH*2-1:0]  ch_edge_cfg,
    input logic [NUM_CH-1:0]    ch_irq_en,
    input logic [NUM_CH-1:0]    irq_clr,
    input logic                 cnt_mode,
    input logic [NUM_CH-1:0]    cnt_src_sel,
    input logic                 presc_tick,
    input logic [NUM_CH*TW-1:0] cap_val,
    input logic [NUM_CH-1:0]    irq_flag,
    input logic                 irq,
    input logic                 count_pulse
);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
            // R4: a disabled channel keeps its snapshot.
            p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(ch_edge_cfg[g*2 +: 2]) == 2'b00) |-> $stable(cap_val[g*TW +: TW]));
            // R5: a flag rises only while its enable was set.
            p_irq_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_flag[g]) |-> $past(ch_irq_en[g]));
            // R6: a set flag stays set unless a clear was requested.
            p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(irq_flag[g]) && !$past(irq_clr[g])) |-> irq_flag[g]);
        end
    endgenerate

    // R7: counter-mode pulses last one cycle.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode && count_pulse) |=> (!count_pulse || !cnt_mode));
    // R8: an empty source mask gives no pulses.
    p_no_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode && cnt_src_sel == '0) |-> !count_pulse);
    // R9: timer mode follows the prescaled tick.
    p_timer_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_mode |-> (count_pulse == presc_tick));
    // R5: the combined request agrees with the flags.
    p_irq_any_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_flag != '0));

endmodule

bind edge_capture_unit edge_capture_unit_chk #(
    .NUM_CH (NUM_CH),
    .TW     (TW)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_edge_cfg (ch_edge_cfg),
    .ch_irq_en   (ch_irq_en),
    .irq_clr     (irq_clr),
    .cnt_mode    (cnt_mode),
    .cnt_src_sel (cnt_src_sel),
    .presc_tick  (presc_tick),
    .cap_val     (cap_val),
    .irq_flag    (irq_flag),
    .irq         (irq),
    .count_pulse (count_pulse)
);

// File: tb/edge_capture_unit_tb_top.sv
// Scoreboard bench: the driver predicts captures into a queue, and the
// monitor pops and compares them as the snapshot registers change.
module edge_capture_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int TW  = 32;

    typedef struct {
        int          ch;
        logic [31:0] val;
    } cap_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    pins = '0;
    logic [TW-1:0]     tv = '0;
    logic [NCH*2-1:0]  cfg = '0;
    logic [NCH-1:0]    ien = '0;
    logic [NCH-1:0]    clr = '0;
    logic              cmode = 1'b0;
    logic [NCH-1:0]    csel = '0;
    logic              ptick = 1'b0;
    logic [NCH*TW-1:0] cap_val;
    logic [NCH-1:0]    irq_flag;
    logic              irq;
    logic              count_pulse;

    int compared = 0;
    int mismatched = 0;
    int pulse_total = 0;
    cap_item_t exp_q[$];
    logic [NCH*TW-1:0] cap_prev = '0;

    edge_capture_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_pins    (pins),
        .timer_val   (tv),
        .ch_edge_cfg (cfg),
        .ch_irq_en   (ien),
        .irq_clr     (clr),
        .cnt_mode    (cmode),
        .cnt_src_sel (csel),
        .presc_tick  (ptick),
        .cap_val     (cap_val),
        .irq_flag    (irq_flag),
        .irq         (irq),
        .count_pulse (count_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running timer value owned by the bench.
    always_ff @(posedge clk) tv <= tv + 32'd1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare each snapshot change against the predicted queue; count pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (count_pulse) pulse_total++;
            for (int c = 0; c < NCH; c++) begin
                if (cap_val[c*TW +: TW] != cap_prev[c*TW +: TW]) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4", "unexpected capture", cap_val[c*TW +: TW], 32'd0);
                    end else begin
                        cap_item_t it;
                        it = exp_q.pop_front();
                        check(it.ch == c, "R2", "capture channel", c, it.ch);
                        check(it.val == cap_val[c*TW +: TW], "R3", "capture value",
                              cap_val[c*TW +: TW], it.val);
                    end
                end
            end
            cap_prev = cap_val;
        end
    end

    // Driver: flip one pin and predict the snapshot if the select qualifies it.
    task automatic toggle_pin(input int ch);
        bit rising;
        @(negedge clk);
        pins[ch] = ~pins[ch];
        rising = pins[ch];
        if ((rising && cfg[2*ch]) || (!rising && cfg[2*ch+1]))
            exp_q.push_back('{ch: ch, val: tv + 32'd2});
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : stim
        int base;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check(cap_val == '0, "R1", "snapshots after reset", cap_val[31:0], 0);
        check(irq_flag == '0 && !irq, "R1", "flags after reset", {irq, irq_flag}, 0);
        rst_n = 1'b1;
        // R2: ch0 rising only, ch1 falling only, ch2 both, ch3 disabled.
        cfg = 8'b00_11_10_01;
        ien = 4'b1001;
        repeat (3) @(negedge clk);
        toggle_pin(0); toggle_pin(0);
        toggle_pin(1); toggle_pin(1);
        toggle_pin(2); toggle_pin(2);
        // R4: disabled channel with interrupt enabled.
        toggle_pin(3); toggle_pin(3);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3", "pending captures", exp_q.size(), 0);
        check(cap_val[3*TW +: TW] == '0, "R4", "disabled snapshot", cap_val[3*TW +: TW], 0);
        check(irq_flag[3] == 1'b0, "R4", "disabled flag", irq_flag[3], 0);
        // R5: only enabled channels raise flags.
        check(irq_flag == 4'b0001, "R5", "flags", irq_flag, 4'b0001);
        check(irq == 1'b1, "R5", "combined irq", irq, 1);
        // R6: sticky until cleared.
        repeat (5) @(negedge clk);
        check(irq_flag[0] == 1'b1, "R6", "flag held", irq_flag[0], 1);
        clr = 4'b0001;
        @(negedge clk);
        clr = '0;
        check(irq_flag == '0 && !irq, "R6", "flag cleared", irq_flag, 0);
        // R6: capture and clear on the same edge; the capture wins.
        @(negedge clk);
        pins[0] = 1'b1;
        exp_q.push_back('{ch: 0, val: tv + 32'd2});
        @(negedge clk);
        @(negedge clk);
        clr = 4'b0001;
        @(negedge clk);
        clr = '0;
        check(irq_flag[0] == 1'b1, "R6", "set beats clear", irq_flag[0], 1);
        toggle_pin(0);
        // R7/R8: counter mode, mask selects ch1 over ch2.
        cmode = 1'b1;
        csel = 4'b0110;
        repeat (2) @(negedge clk);
        base = pulse_total;
        toggle_pin(2); toggle_pin(2); toggle_pin(2); toggle_pin(2);
        check(pulse_total == base, "R8", "pulses from non-lowest channel", pulse_total - base, 0);
        base = pulse_total;
        toggle_pin(1); toggle_pin(1); toggle_pin(1); toggle_pin(1);
        check(pulse_total - base == 2, "R7", "one pulse per falling edge", pulse_total - base, 2);
        // R7: both-edge channel as source.
        csel = 4'b0100;
        repeat (2) @(negedge clk);
        base = pulse_total;
        toggle_pin(2); toggle_pin(2); toggle_pin(2);
        check(pulse_total - base == 3, "R7", "both-edge pulses", pulse_total - base, 3);
        // R8: empty mask.
        csel = '0;
        base = pulse_total;
        toggle_pin(2); toggle_pin(1);
        ptick = 1'b1;
        repeat (3) @(negedge clk);
        ptick = 1'b0;
        check(pulse_total == base, "R8", "empty mask pulses", pulse_total - base, 0);
        // R9: timer mode passes the tick through.
        cmode = 1'b0;
        base = pulse_total;
        toggle_pin(2);
        ptick = 1'b1;
        repeat (3) @(negedge clk);
        ptick = 1'b0;
        repeat (2) @(negedge clk);
        check(pulse_total - base == 3, "R9", "tick passthrough", pulse_total - base, 3);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all captures seen", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule